// File: doc/BRIEF.md
# I2C Bit-Timing Generator with SDA Output Delay and Input Filter

This block turns the peripheral clock into the bit timing of an I2C master. A coarse prescaler, chosen by one select bit as divide-by-16 or divide-by-512, runs in series with a 4-bit scale stage. Together they produce a quarter-bit tick for the byte engine, plus a marker on the tick that closes each bit. The SCL bit period is the prescale value times (scale + 1) input clocks. A new divider setting is adopted only at a bit boundary, so a setting change never shortens or stretches the bit in flight.

On the output side, the SDA drive enable from the byte engine can be held back by 0, 5, 10 or 15 clocks. This gives data hold time after SCL falls. On the input side, an optional filter removes short glitches from the sampled SDA and SCL lines. A level passes the filter only after it has been seen on three consecutive clocks.

Top module: `i2c_scl_timer`

## Requirements
- R1: With `presc_sel`=0 the quarter-bit tick `qtick` repeats every 4×(scale+1) clocks. With `presc_sel`=1 it repeats every 128×(scale+1) clocks. A full bit is therefore 16 or 512 times (scale+1) clocks.
- R2: `scale` is a 4-bit value holding the stage divisor minus one, so values 0 and 15 give stage divisors 1 and 16.
- R3: `bit_end` is high together with every fourth `qtick`, and never without `qtick`.
- R4: While `enable` is low, `qtick` and `bit_end` stay low and the divider restarts from zero. The select and scale inputs are taken up continuously during this time.
- R5: A change to `presc_sel` or `scale` while enabled is ignored until the `qtick` that carries `bit_end`. The next bit uses the new setting.
- R6: With `sda_dly`=d (d=1..3), `sda_oe_out` follows `sda_oe_in` delayed by 5×d clocks.
- R7: With `sda_dly`=0, `sda_oe_out` equals `sda_oe_in` in the same cycle, with no register in the path.
- R8: With `filt_en`=1, `sda_in_f` and `scl_in_f` take a new raw level only after that level has been present on three consecutive rising clock edges. Pulses of one or two clocks are removed.
- R9: With `filt_en`=0, `sda_in_f` and `scl_in_f` equal the raw inputs in the same cycle.
- R10: After reset, `qtick`=0 and `bit_end`=0, the filtered inputs read 1 (idle bus), and the delay line holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low reset |
| enable | input | 1 | Runs the bit-timing divider |
| presc_sel | input | 1 | Prescaler select: 0 gives 16, 1 gives 512 |
| scale | input | 4 | Scale stage divisor minus one |
| sda_dly | input | 2 | SDA output delay in steps of 5 clocks |
| filt_en | input | 1 | Enables the input glitch filter |
| sda_oe_in | input | 1 | SDA drive enable from the byte engine |
| sda_in_raw | input | 1 | Raw SDA line level |
| scl_in_raw | input | 1 | Raw SCL line level |
| qtick | output | 1 | Quarter-bit tick, one clock wide |
| bit_end | output | 1 | Marks the tick that ends a bit |
| sda_oe_out | output | 1 | Delayed SDA drive enable |
| sda_in_f | output | 1 | Filtered SDA level |
| scl_in_f | output | 1 | Filtered SCL level |

## Verification
The assertions check on every cycle that:
- no tick appears while disabled;
- `bit_end` never appears without a tick;
- two ticks are never adjacent;
- the adopted divider setting holds still except after a bit end;
- a filtered line only moves to a level the raw line already showed.

Only the bench scenarios can show the exact tick spacing for each prescale and scale value, the four-tick grouping, the 5/10/15-clock SDA delays, and the rejection of two-clock glitches. They also show the exact tick sequence when the scale is changed in the middle of a bit.

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer #(
  parameter int PS_LO    = 16,
  parameter int PS_HI    = 512,
  parameter int SCALE_W  = 4,
  parameter int DLY_W    = 2,
  parameter int DLY_UNIT = 5,
  parameter int FILT_LEN = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               presc_sel,
  input  logic [SCALE_W-1:0] scale,
  input  logic [DLY_W-1:0]   sda_dly,
  input  logic               filt_en,
  input  logic               sda_oe_in,
  input  logic               sda_in_raw,
  input  logic               scl_in_raw,
  output logic               qtick,
  output logic               bit_end,
  output logic               sda_oe_out,
  output logic               sda_in_f,
  output logic               scl_in_f
);
  localparam int Q_LO      = PS_LO / 4;
  localparam int Q_HI      = PS_HI / 4;
  localparam int PC_W      = $clog2(Q_HI);
  localparam int N_TAPS    = 1 << DLY_W;
  localparam int DLY_DEPTH = DLY_UNIT * (N_TAPS - 1);

  logic               pre_sel_q;
  logic [SCALE_W-1:0] scale_q;
  logic [PC_W-1:0]    pre_cnt;
  logic [SCALE_W-1:0] sc_cnt;
  logic [1:0]         phase;
  logic               pre_hit;

  wire [PC_W-1:0] pre_top = pre_sel_q ? PC_W'(Q_HI - 1) : PC_W'(Q_LO - 1);

  assign pre_hit = enable && (pre_cnt == pre_top);
  assign qtick   = pre_hit && (sc_cnt == scale_q);
  assign bit_end = qtick && (phase == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_sel_q <= 1'b0;
      scale_q   <= '0;
      pre_cnt   <= '0;
      sc_cnt    <= '0;
      phase     <= '0;
    end else if (!enable) begin
      pre_sel_q <= presc_sel;
      scale_q   <= scale;
      pre_cnt   <= '0;
      sc_cnt    <= '0;
      phase     <= '0;
    end else begin
      pre_cnt <= pre_hit ? '0 : pre_cnt + 1'b1;
      if (pre_hit) sc_cnt <= qtick ? '0 : sc_cnt + 1'b1;
      if (qtick)   phase  <= phase + 1'b1;
      if (bit_end) begin
        pre_sel_q <= presc_sel;
        scale_q   <= scale;
      end
    end
  end

  logic [DLY_DEPTH-1:0] dly_sr;
  logic [N_TAPS-1:0]    taps;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dly_sr <= '0;
    else        dly_sr <= {dly_sr[DLY_DEPTH-2:0], sda_oe_in};
  end

  assign taps[0] = sda_oe_in;
  for (genvar k = 1; k < N_TAPS; k++) begin : g_tap
    assign taps[k] = dly_sr[k*DLY_UNIT-1];
  end
  assign sda_oe_out = taps[sda_dly];

  logic [1:0] raw_in, filt_out;
  assign raw_in = {scl_in_raw, sda_in_raw};

  for (genvar i = 0; i < 2; i++) begin : g_filt
    logic [FILT_LEN-2:0] hist;
    logic                lvl;
    wire all_hi = &{hist, raw_in[i]};
    wire all_lo = ~|{hist, raw_in[i]};
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hist <= '1;
        lvl  <= 1'b1;
      end else begin
        hist <= {hist[FILT_LEN-3:0], raw_in[i]};
        if (all_hi)      lvl <= 1'b1;
        else if (all_lo) lvl <= 1'b0;
      end
    end
    assign filt_out[i] = filt_en ? lvl : raw_in[i];
  end

  assign sda_in_f = filt_out[0];
  assign scl_in_f = filt_out[1];
endmodule

// File: rtl/i2c_scl_timer_chk.sv
module i2c_scl_timer_chk #(
  parameter int SCALE_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               enable,
  input logic               filt_en,
  input logic               sda_in_raw,
  input logic               scl_in_raw,
  input logic               qtick,
  input logic               bit_end,
  input logic               sda_in_f,
  input logic               scl_in_f,
  input logic               pre_sel_q,
  input logic [SCALE_W-1:0] scale_q
);
  assert_idle_no_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !qtick);

  assert_end_with_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |-> qtick);

  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    qtick |=> !qtick);

  assert_cfg_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && !$past(bit_end)) |-> ($stable(scale_q) && $stable(pre_sel_q)));

  assert_scl_filter_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_en && $past(filt_en) && (scl_in_f != $past(scl_in_f))) |-> (scl_in_f == $past(scl_in_raw)));

  assert_sda_filter_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_en && $past(filt_en) && (sda_in_f != $past(sda_in_f))) |-> (sda_in_f == $past(sda_in_raw)));
endmodule

bind i2c_scl_timer i2c_scl_timer_chk #(.SCALE_W(SCALE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .filt_en(filt_en),
  .sda_in_raw(sda_in_raw), .scl_in_raw(scl_in_raw), .qtick(qtick),
  .bit_end(bit_end), .sda_in_f(sda_in_f), .scl_in_f(scl_in_f),
  .pre_sel_q(pre_sel_q), .scale_q(scale_q)
);

// File: tb/i2c_scl_timer_bench.sv
module i2c_scl_timer_bench;
  logic clk = 0, rst_n = 0;
  logic enable = 0, presc_sel = 0, filt_en = 0;
  logic [3:0] scale = 0;
  logic [1:0] sda_dly = 0;
  logic sda_oe_in = 0, sda_in_raw = 1, scl_in_raw = 1;
  logic qtick, bit_end, sda_oe_out, sda_in_f, scl_in_f;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  i2c_scl_timer u_i2c_scl_timer (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_tick(output int n);
    n = 0;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      n++;
      if (qtick) return;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R10 qtick", qtick, 0);
    chk("R10 bit_end", bit_end, 0);
    chk("R10 sda_in_f", sda_in_f, 1);
    chk("R10 scl_in_f", scl_in_f, 1);
    sda_dly = 2'd3;
    #1 chk("R10 sda_oe_out", sda_oe_out, 0);
  endtask

  task automatic t_disabled();
    int seen = 0;
    enable = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (qtick || bit_end) seen++;
    end
    chk("R4 ticks while disabled", seen, 0);
  endtask

  task automatic t_period(bit sel, int sc);
    int n, exp, cnt;
    @(negedge clk);
    enable = 0; presc_sel = sel; scale = 4'(sc);
    @(negedge clk);
    enable = 1;
    exp = (sel ? 128 : 4) * (sc + 1);
    wait_tick(n);
    for (int k = 0; k < 4; k++) begin
      wait_tick(n);
      chk($sformatf("R1 R2 interval sel=%0d scale=%0d", sel, sc), n, exp);
    end
    while (!bit_end) wait_tick(n);
    cnt = 0;
    do begin wait_tick(n); cnt++; end while (!bit_end);
    chk("R3 ticks per bit", cnt, 4);
    enable = 0;
  endtask

  task automatic t_boundary();
    int n;
    @(negedge clk);
    enable = 0; presc_sel = 0; scale = 4'd3;
    @(negedge clk);
    enable = 1;
    do wait_tick(n); while (!bit_end);
    @(negedge clk); @(negedge clk);
    scale = 4'd1;
    wait_tick(n); chk("R5 old setting phase0", n, 14);
    wait_tick(n); chk("R5 old setting phase1", n, 16);
    wait_tick(n); chk("R5 old setting phase2", n, 16);
    wait_tick(n); chk("R5 old setting phase3", n, 16);
    chk("R5 bit_end at boundary", bit_end, 1);
    wait_tick(n); chk("R5 new setting", n, 8);
    enable = 0;
  endtask

  task automatic t_delay(int d);
    @(negedge clk);
    sda_dly = 2'(d); sda_oe_in = 0;
    repeat (20) @(negedge clk);
    sda_oe_in = 1;
    if (d == 0) begin
      #1 chk("R7 same-cycle pass", sda_oe_out, 1);
      @(negedge clk); sda_oe_in = 0;
      #1 chk("R7 same-cycle fall", sda_oe_out, 0);
    end else begin
      repeat (5*d - 1) @(negedge clk);
      chk($sformatf("R6 held d=%0d", d), sda_oe_out, 0);
      @(negedge clk);
      chk($sformatf("R6 arrived d=%0d", d), sda_oe_out, 1);
    end
  endtask

  task automatic t_filter();
    @(negedge clk);
    filt_en = 1; scl_in_raw = 1; sda_in_raw = 1;
    repeat (5) @(negedge clk);
    scl_in_raw = 0; sda_in_raw = 0;
    @(negedge clk); chk("R8 glitch edge1", scl_in_f, 1);
    @(negedge clk); chk("R8 glitch edge2", sda_in_f, 1);
    scl_in_raw = 1; sda_in_raw = 1;
    repeat (3) @(negedge clk);
    chk("R8 glitch removed scl", scl_in_f, 1);
    chk("R8 glitch removed sda", sda_in_f, 1);
    scl_in_raw = 0;
    @(negedge clk); @(negedge clk);
    chk("R8 two clocks not enough", scl_in_f, 0 + 1);
    @(negedge clk);
    chk("R8 three clocks pass", scl_in_f, 0);
    chk("R8 other line untouched", sda_in_f, 1);
  endtask

  task automatic t_nofilt();
    @(negedge clk);
    filt_en = 0; sda_in_raw = 0; scl_in_raw = 1;
    #1 chk("R9 sda passthrough", sda_in_f, 0);
    chk("R9 scl passthrough", scl_in_f, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_disabled();
    t_period(0, 0);
    t_period(0, 15);
    t_period(1, 2);
    t_boundary();
    t_delay(0);
    t_delay(1);
    t_delay(2);
    t_delay(3);
    t_filter();
    t_nofilt();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule